// File: doc/BRIEF.md
# Double-Edge Serial Lane Receiver with Word Framing

This block turns one or more single-bit serial lanes into parallel words. A forwarded bit clock runs at six times the word rate, and data is captured on both of its edges, so a word of twelve bits arrives over six bit-clock periods. A forwarded frame clock runs at the word rate. Its rising transition marks the first bit of every word, and that rising transition may fall on either edge of the bit clock. Every lane uses the same frame boundary. Each lane is shifted into its own register.

Bits are assembled least significant first by default. A bit-order input reverses the finished word when the transmitter sends the most significant bit first. Each finished word set is presented together with a one-cycle valid strobe. While sync checking is enabled, every finished word is compared against the fixed sync word. An alignment flag rises after a run of consecutive matches and drops on the first miss. The bit clock is assumed to be centred on the data eye already.

Top module: `ddr_frame_rx`

## Requirements
- R1: A data bit is taken on each rising and each falling edge of the bit clock, so one word of WORD_W bits (default 12) spans WORD_W/2 bit-clock periods.
- R2: The bit sampled at the same edge where the frame input first reads 1 after reading 0 on the previous edge becomes bit 0 of a new word. This holds whether that edge is a rising or a falling edge of the bit clock.
- R3: With `msb_first_i` low, the first bit received in a word is placed in output bit 0 and the last bit received is placed in bit WORD_W-1.
- R4: With `msb_first_i` high, the assembled word is bit-reversed, so the first bit received lands in bit WORD_W-1.
- R5: `word_vld_o` is high for exactly one bit-clock cycle per completed word. It is never high on two consecutive cycles, and it never pulses before the first frame edge after reset. `word_o` changes only together with `word_vld_o`.
- R6: Lane n of `word_o` occupies bits [n*WORD_W +: WORD_W] and depends only on `data_i[n]`. All lanes share one word boundary.
- R7: While `sync_chk_i` is high, `aligned_o` rises with the SYNC_HITS-th consecutive word (default 4) in which every lane's output word equals the sync word 12'hFC0. In serial order that sync word is six zeros followed by six ones in least-first order, and in output order it is the same value 12'hFC0 when bit order is reversed.
- R8: While `sync_chk_i` is high, any output word set in which a lane differs from 12'hFC0 clears `aligned_o` and restarts the count of consecutive matches.
- R9: While `sync_chk_i` is low, received words do not change `aligned_o` or the match count.
- R10: After reset, `word_o` is zero, and `word_vld_o` and `aligned_o` are low.
- R11: A stream that alternates 0,1,0,1,… starting with 0 at the frame edge produces 12'hAAA on every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit_i | input | 1 | Forwarded bit clock; data and frame are taken on both edges |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | Forwarded word-rate frame clock |
| data_i | input | LANES | One serial bit per lane |
| msb_first_i | input | 1 | High: reverse each assembled word |
| sync_chk_i | input | 1 | High: compare finished words against the sync word |
| word_o | output | LANES*WORD_W | Parallel words, lane 0 in the low bits |
| word_vld_o | output | 1 | One-cycle strobe per finished word set |
| aligned_o | output | 1 | Sync alignment status |

## Verification
The bench places the frame edge on a falling bit-clock edge as well as a rising one. A receiver that assumed a single phase would emit words rotated by one bit. The alternating stream exposes a receiver that drops either the rising or the falling edge, because such a design would return all zeros or all ones instead of 12'hAAA. The sync tests send three matching words and then a fourth, and they inject a single mismatching lane in the middle of a run. An off-by-one in the match counter, or a counter that is not cleared on a miss, shows up in the state of the alignment flag. Words sent while checking is disabled must leave the flag set. The sync word is also sent in reversed bit order, which catches a comparator placed before the reversal instead of after it.

// File: rtl/ddr_frame_rx.sv
`timescale 1ns/1ps
module ddr_frame_rx #(
  parameter int LANES     = 4,
  parameter int WORD_W    = 12,
  parameter int SYNC_HITS = 4
) (
  input  logic                    clk_bit_i,
  input  logic                    rst_n_i,
  input  logic                    frame_i,
  input  logic [LANES-1:0]        data_i,
  input  logic                    msb_first_i,
  input  logic                    sync_chk_i,
  output logic [LANES*WORD_W-1:0] word_o,
  output logic                    word_vld_o,
  output logic                    aligned_o
);
  localparam int PAIRS = WORD_W / 2;
  localparam int CNT_W = $clog2(PAIRS + 2);
  localparam int HIT_W = $clog2(SYNC_HITS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(PAIRS + 1);
  localparam logic [CNT_W-1:0] CNT_EVEN = CNT_W'(PAIRS - 1);
  localparam logic [CNT_W-1:0] CNT_ODD  = CNT_W'(PAIRS);
  localparam logic [HIT_W-1:0] HIT_TOP  = HIT_W'(SYNC_HITS);
  localparam logic [HIT_W-1:0] HIT_LAST = HIT_W'(SYNC_HITS - 1);
  localparam logic [WORD_W-1:0] SYNC_WORD = {{PAIRS{1'b1}}, {PAIRS{1'b0}}};

  logic [LANES-1:0] d_rise, d_fall;
  logic             f_rise, f_fall, f_fall_q;
  logic [CNT_W-1:0] cnt;
  logic             odd_q;
  logic [HIT_W-1:0] hits;
  logic [LANES*WORD_W-1:0] fmt_all;
  logic [LANES-1:0] lane_ok;

  always_ff @(posedge clk_bit_i or negedge rst_n_i)
    if (!rst_n_i) begin
      d_rise <= '0;
      f_rise <= 1'b0;
    end else begin
      d_rise <= data_i;
      f_rise <= frame_i;
    end

  always_ff @(negedge clk_bit_i or negedge rst_n_i)
    if (!rst_n_i) begin
      d_fall <= '0;
      f_fall <= 1'b0;
    end else begin
      d_fall <= data_i;
      f_fall <= frame_i;
    end

  wire edge_even = f_rise & ~f_fall_q;
  wire edge_odd  = f_fall & ~f_rise;
  wire emit      = odd_q ? (cnt == CNT_ODD) : (cnt == CNT_EVEN);

  always_ff @(posedge clk_bit_i or negedge rst_n_i)
    if (!rst_n_i) begin
      f_fall_q <= 1'b0;
      cnt      <= CNT_MAX;
      odd_q    <= 1'b0;
    end else begin
      f_fall_q <= f_fall;
      if (edge_even || edge_odd) begin
        cnt   <= CNT_W'(1);
        odd_q <= edge_odd;
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + CNT_W'(1);
      end
    end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [WORD_W:0]   sh;
    logic [WORD_W:0]   sh_nx;
    logic [WORD_W-1:0] asm_w, rev_w, fmt_w;
    assign sh_nx = {d_fall[l], d_rise[l], sh[WORD_W:2]};
    always_ff @(posedge clk_bit_i or negedge rst_n_i)
      if (!rst_n_i) sh <= '0;
      else          sh <= sh_nx;
    assign asm_w = odd_q ? sh_nx[WORD_W-1:0] : sh_nx[WORD_W:1];
    for (genvar b = 0; b < WORD_W; b++) begin : g_rev
      assign rev_w[b] = asm_w[WORD_W-1-b];
    end
    assign fmt_w = msb_first_i ? rev_w : asm_w;
    assign fmt_all[l*WORD_W +: WORD_W] = fmt_w;
    assign lane_ok[l] = (fmt_w == SYNC_WORD);
  end

  always_ff @(posedge clk_bit_i or negedge rst_n_i)
    if (!rst_n_i) begin
      word_o     <= '0;
      word_vld_o <= 1'b0;
      hits       <= '0;
      aligned_o  <= 1'b0;
    end else begin
      word_vld_o <= emit;
      if (emit) word_o <= fmt_all;
      if (emit && sync_chk_i) begin
        if (&lane_ok) begin
          if (hits != HIT_TOP) hits <= hits + HIT_W'(1);
          if (hits >= HIT_LAST) aligned_o <= 1'b1;
        end else begin
          hits      <= '0;
          aligned_o <= 1'b0;
        end
      end
    end

  p_vld_single_r5: assert property (@(posedge clk_bit_i) disable iff (!rst_n_i)
    word_vld_o |=> !word_vld_o);
  p_word_hold_r5: assert property (@(posedge clk_bit_i) disable iff (!rst_n_i)
    !word_vld_o |-> $stable(word_o));
  p_set_on_sync_r7: assert property (@(posedge clk_bit_i) disable iff (!rst_n_i)
    $rose(aligned_o) |-> (word_vld_o && $past(sync_chk_i) && word_o[WORD_W-1:0] == SYNC_WORD));
  p_clr_on_word_r8: assert property (@(posedge clk_bit_i) disable iff (!rst_n_i)
    $fell(aligned_o) |-> (word_vld_o && $past(sync_chk_i)));
  p_hold_when_off_r9: assert property (@(posedge clk_bit_i) disable iff (!rst_n_i)
    !$past(sync_chk_i) |-> $stable(aligned_o));
endmodule

// File: tb/ddr_frame_rx_tb_top.sv
`timescale 1ns/1ps
module ddr_frame_rx_tb_top;
  localparam int LANES = 4;
  localparam int W     = 12;
  localparam int LW    = LANES * W;

  logic clk = 1'b0, rst_n = 1'b0, frame = 1'b0, msb = 1'b0, schk = 1'b0;
  logic [LANES-1:0] din = '0;
  logic [LW-1:0] word;
  logic vld, aligned;

  ddr_frame_rx dut_i (
    .clk_bit_i(clk), .rst_n_i(rst_n), .frame_i(frame), .data_i(din),
    .msb_first_i(msb), .sync_chk_i(schk),
    .word_o(word), .word_vld_o(vld), .aligned_o(aligned)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [LW-1:0] got [64];
  int ng = 0, dbl = 0;
  logic prev_v = 1'b0;

  always @(negedge clk) begin
    if (vld) begin
      if (ng < 64) got[ng] = word;
      ng++;
      if (prev_v) dbl++;
    end
    prev_v = vld;
  end

  task automatic chk(input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] mk(input int s);
    logic [LW-1:0] r;
    for (int l = 0; l < LANES; l++) r[l*W +: W] = W'(s * 149 + l * 1337 + 77);
    return r;
  endfunction

  function automatic logic [LW-1:0] rev_lanes(input logic [LW-1:0] x);
    logic [LW-1:0] r;
    for (int l = 0; l < LANES; l++)
      for (int b = 0; b < W; b++) r[l*W + b] = x[l*W + W-1-b];
    return r;
  endfunction

  function automatic logic [LW-1:0] fill(input logic [W-1:0] v);
    logic [LW-1:0] r;
    for (int l = 0; l < LANES; l++) r[l*W +: W] = v;
    return r;
  endfunction

  task automatic drive_bit(input logic fr, input logic [LANES-1:0] d);
    @(clk);
    #1.25;
    frame = fr;
    din   = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive_bit(1'b0, '0);
  endtask

  task automatic send_word(input logic [LW-1:0] w, input logic ser_msb);
    for (int i = 0; i < W; i++) begin
      logic [LANES-1:0] d;
      int idx;
      idx = ser_msb ? W-1-i : i;
      for (int l = 0; l < LANES; l++) d[l] = w[l*W + idx];
      drive_bit(i < W/2, d);
    end
  endtask

  task automatic burst(input logic odd, input logic ser_msb, input int n,
                       input logic [LW-1:0] ws [4], output int base);
    if (odd) @(negedge clk); else @(posedge clk);
    base = ng;
    idle(4);
    for (int i = 0; i < n; i++) send_word(ws[i], ser_msb);
    idle(6);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 word after reset", word, '0);
    chk("R10 valid after reset", LW'(vld), '0);
    chk("R10 aligned after reset", LW'(aligned), '0);
  endtask

  task automatic t_phase(input logic odd);
    logic [LW-1:0] ws [4];
    int base, d0;
    for (int i = 0; i < 4; i++) ws[i] = mk(i + (odd ? 11 : 1));
    d0 = dbl;
    burst(odd, 1'b0, 3, ws, base);
    chk("R5 one strobe per word", LW'(ng - base), LW'(3));
    chk("R5 no back-to-back strobe", LW'(dbl - d0), '0);
    for (int i = 0; i < 3; i++)
      chk(odd ? "R2 R6 word with frame edge on falling edge"
              : "R1 R3 R6 word with frame edge on rising edge",
          got[base + i], ws[i]);
  endtask

  task automatic t_msb();
    logic [LW-1:0] ws [4];
    int base;
    for (int i = 0; i < 4; i++) ws[i] = mk(i + 31);
    msb = 1'b1;
    burst(1'b0, 1'b1, 2, ws, base);
    chk("R4 msb-first stream restored", got[base], ws[0]);
    chk("R4 msb-first stream restored", got[base + 1], ws[1]);
    burst(1'b1, 1'b0, 1, ws, base);
    chk("R4 reversal of lsb-first stream", got[base], rev_lanes(ws[0]));
    msb = 1'b0;
  endtask

  task automatic t_deskew();
    logic [LW-1:0] ws [4];
    int base;
    for (int i = 0; i < 4; i++) ws[i] = fill(12'hAAA);
    burst(1'b0, 1'b0, 2, ws, base);
    chk("R11 alternating stream", got[base + 1], fill(12'hAAA));
    burst(1'b1, 1'b0, 1, ws, base);
    chk("R11 alternating stream odd phase", got[base], fill(12'hAAA));
  endtask

  task automatic t_sync();
    logic [LW-1:0] ws [4], bad [4];
    int base;
    for (int i = 0; i < 4; i++) ws[i] = fill(12'hFC0);
    bad[0] = fill(12'hFC0);
    bad[0][2*W +: W] = 12'hFC1;
    for (int i = 1; i < 4; i++) bad[i] = mk(i + 50);
    do_reset();
    schk = 1'b1;
    burst(1'b0, 1'b0, 3, ws, base);
    chk("R7 three sync words not enough", LW'(aligned), '0);
    burst(1'b0, 1'b0, 1, ws, base);
    chk("R7 fourth sync word aligns", LW'(aligned), LW'(1));
    burst(1'b1, 1'b0, 1, bad, base);
    chk("R8 one lane mismatch clears", LW'(aligned), '0);
    burst(1'b0, 1'b0, 3, ws, base);
    chk("R8 count restarted after miss", LW'(aligned), '0);
    burst(1'b0, 1'b0, 1, ws, base);
    chk("R8 realigned after four more", LW'(aligned), LW'(1));
    schk = 1'b0;
    burst(1'b0, 1'b0, 2, bad, base);
    chk("R9 words received while off", got[base + 1], bad[1]);
    chk("R9 flag kept while off", LW'(aligned), LW'(1));
    schk = 1'b1;
  endtask

  task automatic t_msb_sync();
    logic [LW-1:0] ws [4];
    int base;
    for (int i = 0; i < 4; i++) ws[i] = fill(12'hFC0);
    do_reset();
    msb  = 1'b1;
    schk = 1'b1;
    burst(1'b1, 1'b1, 4, ws, base);
    chk("R7 reversed-order sync word value", got[base + 3], fill(12'hFC0));
    chk("R7 aligns in msb-first mode", LW'(aligned), LW'(1));
    msb = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 no strobe before frame edge", LW'(ng), '0);
    t_phase(1'b0);
    t_phase(1'b1);
    t_msb();
    t_deskew();
    t_sync();
    t_msb_sync();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule